// File: doc/BRIEF.md
# Device-Failure-Tolerant Symbol ECC Codec

This block protects a 128-bit memory word with 16 check bits so that the failure of any single 4-bit-wide memory device can be repaired on the fly. The 144-bit codeword is cut into 36 four-bit symbols. Symbols 0 to 31 carry data and symbols 32 to 35 carry check bits, and each symbol lives on one device. The code works over GF(16), and its 36 symbol columns are chosen so that any three of them are linearly independent. As a result, every error confined to one symbol is corrected, and every error that spans two symbols is reported and never miscorrected.

The block has two independent paths. The encode path takes 128 data bits and returns the 144-bit codeword. The decode path takes a 144-bit codeword read from memory and returns the data, with one of three outcomes: clean, corrected (with the index of the repaired symbol), or uncorrectable. Each path has a single register stage with a valid/ready handshake on both sides. A 16-byte word fits the usual pattern of a burst of 4 beats per 64-byte line or 8 beats per 128-byte line.

Top module: `chipkill_codec`

## Requirements
- R1: Symbol i of a codeword occupies bits [4i+3:4i]. The encoder places its 128 input data bits unchanged in bits [127:0] of the codeword.
- R2: The encoder output has an all-zero syndrome. The syndrome is the GF(16) sum S = sum over j of col_j·sym_j, using the field polynomial x^4+x+1, and it is packed as {S3,S2,S1,S0} with S0 in bits [3:0]. The column for data symbol i is (1, a²+ab+λb², a, b) with λ = 4'h8. Here n = i+2 for i<14 and n = i+3 otherwise, a = n mod 16 and b = n div 16. The check symbols 32 to 35 use the columns (0,1,0,0), (1,0,0,0), (1,1,1,0) and (1,λ,0,1), each written as (S0,S1,S2,S3) components.
- R3: A received word with a zero syndrome raises only the clean flag, and the data passes through unchanged.
- R4: Any nonzero error pattern (1 to 4 bits) inside any single symbol 0 to 35 raises the corrected flag, reports that symbol's index, and returns the original data.
- R5: Any error that touches two distinct symbols raises the uncorrectable flag and returns the raw received data bits [127:0].
- R6: Every decode result raises exactly one of the three flags clean, corrected and uncorrectable.
- R7: The symbol index is in the range 0 to 35 when the corrected flag is set, and 0 otherwise.
- R8: Each path accepts an input on a clock edge where in_valid and in_ready are both high. The result is presented on out_valid in the following cycle. in_ready equals (not out_valid) or out_ready.
- R9: While out_valid is high and out_ready is low, the output valid and the output payload hold their values.
- R10: After reset, both out_valid signals are low and both in_ready signals are high.
- R11: A stall on the decode output does not block the encode path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_in_valid | input | 1 | Encode request valid |
| enc_in_ready | output | 1 | Encode path can accept |
| enc_in_data | input | 128 | Data to encode |
| enc_out_valid | output | 1 | Codeword valid |
| enc_out_ready | input | 1 | Consumer takes codeword |
| enc_out_word | output | 144 | Encoded codeword |
| dec_in_valid | input | 1 | Decode request valid |
| dec_in_ready | output | 1 | Decode path can accept |
| dec_in_word | input | 144 | Received codeword |
| dec_out_valid | output | 1 | Decode result valid |
| dec_out_ready | input | 1 | Consumer takes result |
| dec_out_data | output | 128 | Corrected or raw data |
| dec_out_clean | output | 1 | No error present |
| dec_out_corrected | output | 1 | One symbol repaired |
| dec_out_uncorr | output | 1 | Error beyond one symbol |
| dec_out_sym_idx | output | 6 | Index of repaired symbol |

## Verification
The hardest case to reach from the ports is a two-symbol error whose combined syndrome lies close to the span of a third column. In that case a flawed column set or a flawed locator would mistake the error for a single-symbol fault. The bench builds genuine codewords through the encoder and then injects errors on many symbol pairs, with error values that vary per position. These pairs include pairs of check symbols and mixed data/check pairs, so that every column takes part in a double fault. Single-symbol faults are swept over all 36 positions, and every 4-bit pattern is applied at chosen positions. A stalled output is held for several cycles while the next word waits at the input.

// File: rtl/chipkill_pkg.sv
// Package: GF(16) arithmetic and the fixed symbol-column set of the code.
// Assumes field polynomial x^4+x+1. The columns are points of an elliptic
// quadric in 3-dimensional projective space, so any three are independent.
package chipkill_pkg;
    localparam int SYM_W      = 4;
    localparam int DATA_SYMS  = 32;
    localparam int CHECK_SYMS = 4;
    localparam int NUM_SYMS   = DATA_SYMS + CHECK_SYMS;
    localparam int DATA_W     = DATA_SYMS * SYM_W;
    localparam int WORD_W     = NUM_SYMS * SYM_W;
    localparam int SYND_W     = CHECK_SYMS * SYM_W;
    localparam int IDX_W      = $clog2(NUM_SYMS);
    localparam logic [3:0] LAMBDA = 4'h8;

    // Multiply two field elements.
    function automatic logic [3:0] gf_mul(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] acc;
        logic [3:0] x;
        acc = '0;
        x   = a;
        for (int i = 0; i < 4; i++) begin
            if (b[i]) acc = acc ^ x;
            x = {x[2:0], 1'b0} ^ (x[3] ? 4'h3 : 4'h0);
        end
        return acc;
    endfunction

    // Column of symbol j packed as {h3,h2,h1,h0}.
    function automatic logic [15:0] sym_col(input int unsigned j);
        logic [7:0] n;
        logic [3:0] a;
        logic [3:0] b;
        logic [3:0] f;
        if (j < DATA_SYMS) begin
            n = 8'(j + ((j < 14) ? 2 : 3));
            a = n[3:0];
            b = n[7:4];
            f = gf_mul(a, a) ^ gf_mul(a, b) ^ gf_mul(LAMBDA, gf_mul(b, b));
            return {b, a, f, 4'h1};
        end
        case (j)
            32:      return 16'h0010;
            33:      return 16'h0001;
            34:      return 16'h0111;
            default: return {4'h1, 4'h0, LAMBDA, 4'h1};
        endcase
    endfunction

    // Scale a column by a field element.
    function automatic logic [15:0] col_times(input logic [15:0] col, input logic [3:0] e);
        return {gf_mul(col[15:12], e), gf_mul(col[11:8], e),
                gf_mul(col[7:4], e), gf_mul(col[3:0], e)};
    endfunction

    // Full syndrome of a word, used by checks.
    function automatic logic [15:0] syndrome_of(input logic [WORD_W-1:0] w);
        logic [15:0] s;
        s = '0;
        for (int j = 0; j < NUM_SYMS; j++)
            s = s ^ col_times(sym_col(j), w[SYM_W*j +: SYM_W]);
        return s;
    endfunction
endpackage

// File: rtl/ecc_syndrome.sv
// Module: ecc_syndrome
// Computes the 16-bit syndrome of a 144-bit word, one parallel product per
// symbol with constant columns. Purely combinational.
module ecc_syndrome
    import chipkill_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [SYND_W-1:0] synd
);
    logic [SYND_W-1:0] part [NUM_SYMS];

    for (genvar j = 0; j < NUM_SYMS; j++) begin : g_sym
        assign part[j] = col_times(sym_col(j), word[SYM_W*j +: SYM_W]);
    end

    // XOR-reduce the per-symbol contributions.
    always_comb begin
        synd = '0;
        for (int j = 0; j < NUM_SYMS; j++) synd = synd ^ part[j];
    end
endmodule

// File: rtl/ecc_locator.sv
// Module: ecc_locator
// Tries every symbol column against a nonzero syndrome in parallel and
// reports whether exactly one symbol explains it, plus its index and value.
// Assumes any three columns are independent (single hits are unique).
module ecc_locator
    import chipkill_pkg::*;
(
    input  logic [SYND_W-1:0] synd,
    output logic              single,
    output logic [IDX_W-1:0]  idx,
    output logic [SYM_W-1:0]  err_val
);
    logic [NUM_SYMS-1:0] hit;
    logic [SYM_W-1:0]    cand [NUM_SYMS];

    for (genvar j = 0; j < NUM_SYMS; j++) begin : g_try
        // Symbol 32 has a zero first component, so its value sits in S1.
        if (j == DATA_SYMS) begin : g_s1
            assign cand[j] = synd[7:4];
        end else begin : g_s0
            assign cand[j] = synd[3:0];
        end
        assign hit[j] = (cand[j] != '0) && (col_times(sym_col(j), cand[j]) == synd);
    end

    // Count hits and pick the matching symbol.
    always_comb begin
        int unsigned nhit;
        nhit    = 0;
        idx     = '0;
        err_val = '0;
        for (int j = 0; j < NUM_SYMS; j++) begin
            if (hit[j]) begin
                nhit    = nhit + 1;
                idx     = IDX_W'(j);
                err_val = cand[j];
            end
        end
        single = (nhit == 1);
    end
endmodule

// File: rtl/ecc_pipe_reg.sv
// Module: ecc_pipe_reg
// One register stage with valid/ready on both sides. Payload holds while
// stalled; new data loads when the stage is empty or being drained.
module ecc_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    // Load on accept, empty on drain, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
        end
    end

    a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
    a_r8_accept_shows_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && out_data == $past(in_data));
endmodule

// File: rtl/ecc_encode.sv
// Module: ecc_encode
// Combinational encoder: data symbols' syndrome is folded into four check
// symbols solved for the check columns, giving a zero total syndrome.
module ecc_encode
    import chipkill_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [WORD_W-1:0] word
);
    logic [SYND_W-1:0] s;
    logic [SYM_W-1:0]  p0, p1, p2, p3;

    ecc_syndrome i_synd (.word({{SYND_W{1'b0}}, data}), .synd(s));

    // Solve the triangular system of the check columns.
    always_comb begin
        p3   = s[15:12];
        p2   = s[11:8];
        p1   = s[3:0] ^ s[11:8] ^ s[15:12];
        p0   = s[7:4] ^ s[11:8] ^ gf_mul(LAMBDA, s[15:12]);
        word = {p3, p2, p1, p0, data};
    end
endmodule

// File: rtl/ecc_decode.sv
// Module: ecc_decode
// Combinational decoder: syndrome, locate, repair a data symbol by XOR.
// Raw data passes when the word is clean or uncorrectable.
module ecc_decode
    import chipkill_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [DATA_W-1:0] data,
    output logic              clean,
    output logic              corrected,
    output logic              uncorr,
    output logic [IDX_W-1:0]  sym_idx
);
    logic [SYND_W-1:0] synd;
    logic              single;
    logic [IDX_W-1:0]  loc_idx;
    logic [SYM_W-1:0]  err_val;

    ecc_syndrome i_synd (.word(word), .synd(synd));
    ecc_locator  i_loc  (.synd(synd), .single(single), .idx(loc_idx), .err_val(err_val));

    // Classify and apply the repair.
    always_comb begin
        data      = word[DATA_W-1:0];
        clean     = (synd == '0);
        corrected = !clean && single;
        uncorr    = !clean && !single;
        sym_idx   = corrected ? loc_idx : '0;
        if (corrected && loc_idx < IDX_W'(DATA_SYMS))
            data[{loc_idx[4:0], 2'b00} +: SYM_W] = word[{loc_idx[4:0], 2'b00} +: SYM_W] ^ err_val;
    end
endmodule

// File: rtl/chipkill_codec.sv
// Module: chipkill_codec (top)
// Independent encode and decode paths, each a combinational stage followed
// by one handshake register. Synchronous active-low reset.
module chipkill_codec
    import chipkill_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enc_in_valid,
    output logic               enc_in_ready,
    input  logic [127:0]       enc_in_data,
    output logic               enc_out_valid,
    input  logic               enc_out_ready,
    output logic [143:0]       enc_out_word,
    input  logic               dec_in_valid,
    output logic               dec_in_ready,
    input  logic [143:0]       dec_in_word,
    output logic               dec_out_valid,
    input  logic               dec_out_ready,
    output logic [127:0]       dec_out_data,
    output logic               dec_out_clean,
    output logic               dec_out_corrected,
    output logic               dec_out_uncorr,
    output logic [5:0]         dec_out_sym_idx
);
    localparam int DEC_PW = DATA_W + 3 + IDX_W;

    logic [WORD_W-1:0] enc_word;
    logic [DATA_W-1:0] dec_data;
    logic              dec_clean, dec_corr, dec_unc;
    logic [IDX_W-1:0]  dec_idx;
    logic [DEC_PW-1:0] dec_pay;

    ecc_encode i_enc (.data(enc_in_data), .word(enc_word));

    ecc_pipe_reg #(.W(WORD_W)) i_enc_reg (
        .clk(clk), .rst_n(rst_n),
        .in_valid(enc_in_valid), .in_ready(enc_in_ready), .in_data(enc_word),
        .out_valid(enc_out_valid), .out_ready(enc_out_ready), .out_data(enc_out_word));

    ecc_decode i_dec (
        .word(dec_in_word), .data(dec_data), .clean(dec_clean),
        .corrected(dec_corr), .uncorr(dec_unc), .sym_idx(dec_idx));

    ecc_pipe_reg #(.W(DEC_PW)) i_dec_reg (
        .clk(clk), .rst_n(rst_n),
        .in_valid(dec_in_valid), .in_ready(dec_in_ready),
        .in_data({dec_clean, dec_corr, dec_unc, dec_idx, dec_data}),
        .out_valid(dec_out_valid), .out_ready(dec_out_ready), .out_data(dec_pay));

    assign {dec_out_clean, dec_out_corrected, dec_out_uncorr, dec_out_sym_idx, dec_out_data} = dec_pay;

    a_r2_enc_zero_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
        enc_out_valid |-> syndrome_of(enc_out_word) == '0);
    a_r6_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid |-> $onehot({dec_out_clean, dec_out_corrected, dec_out_uncorr}));
    a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid && dec_out_corrected |-> dec_out_sym_idx < 6'(NUM_SYMS));
    a_r7_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid && !dec_out_corrected |-> dec_out_sym_idx == '0);
    a_r3_clean_raw: assert property (@(posedge clk) disable iff (!rst_n)
        dec_in_valid && dec_in_ready && syndrome_of(dec_in_word) == '0
        |=> dec_out_clean && dec_out_data == $past(dec_in_word[DATA_W-1:0]));
endmodule

// File: tb/test_chipkill_codec.sv
module test_chipkill_codec;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enc_in_valid = 1'b0;
    logic         enc_in_ready;
    logic [127:0] enc_in_data = '0;
    logic         enc_out_valid;
    logic         enc_out_ready = 1'b1;
    logic [143:0] enc_out_word;
    logic         dec_in_valid = 1'b0;
    logic         dec_in_ready;
    logic [143:0] dec_in_word = '0;
    logic         dec_out_valid;
    logic         dec_out_ready = 1'b1;
    logic [127:0] dec_out_data;
    logic         dec_out_clean, dec_out_corrected, dec_out_uncorr;
    logic [5:0]   dec_out_sym_idx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;  // 250 MHz

    chipkill_codec i_chipkill_codec (.*);

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual run too long, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Independent model of the code from R2.
    function automatic logic [3:0] m_mul(input logic [3:0] a, input logic [3:0] b);
        logic [7:0] p;
        p = '0;
        for (int i = 0; i < 4; i++) if (b[i]) p = p ^ (8'(a) << i);
        for (int k = 7; k >= 4; k--) if (p[k]) p = p ^ (8'h13 << (k - 4));
        return p[3:0];
    endfunction

    function automatic logic [15:0] m_col(input int j);
        int n;
        logic [3:0] a, b;
        if (j == 32) return 16'h0010;
        if (j == 33) return 16'h0001;
        if (j == 34) return 16'h0111;
        if (j == 35) return 16'h1081;
        n = (j < 14) ? j + 2 : j + 3;
        a = 4'(n % 16);
        b = 4'(n / 16);
        return {b, a, m_mul(a, a) ^ m_mul(a, b) ^ m_mul(4'h8, m_mul(b, b)), 4'h1};
    endfunction

    function automatic logic [15:0] m_synd(input logic [143:0] w);
        logic [15:0] s;
        logic [15:0] c;
        s = '0;
        for (int j = 0; j < 36; j++) begin
            c = m_col(j);
            for (int k = 0; k < 4; k++)
                s[4*k +: 4] = s[4*k +: 4] ^ m_mul(c[4*k +: 4], w[4*j +: 4]);
        end
        return s;
    endfunction

    function automatic logic [127:0] pattern(input int seed);
        logic [127:0] v;
        logic [31:0] x;
        x = 32'h9E3779B9 ^ 32'(seed * 747796405);
        for (int i = 0; i < 4; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            v[32*i +: 32] = x;
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [143:0] act, input logic [143:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic encode(input logic [127:0] d, output logic [143:0] w);
        @(negedge clk);
        enc_in_valid = 1'b1;
        enc_in_data  = d;
        @(negedge clk);
        enc_in_valid = 1'b0;
        w = enc_out_word;
        check(enc_out_valid == 1'b1, "R8", "enc out_valid", 144'(enc_out_valid), 144'(1));
    endtask

    task automatic decode_expect(input logic [143:0] w, input logic [127:0] exp_d,
                                 input logic [2:0] exp_flags, input logic [5:0] exp_idx,
                                 input string req);
        @(negedge clk);
        dec_in_valid = 1'b1;
        dec_in_word  = w;
        @(negedge clk);
        dec_in_valid = 1'b0;
        check(dec_out_valid == 1'b1, "R8", "dec out_valid", 144'(dec_out_valid), 144'(1));
        check(dec_out_data == exp_d, req, "data", 144'(dec_out_data), 144'(exp_d));
        check({dec_out_clean, dec_out_corrected, dec_out_uncorr} == exp_flags, req,
              "flags clean/corr/unc",
              144'({dec_out_clean, dec_out_corrected, dec_out_uncorr}), 144'(exp_flags));
        check(dec_out_sym_idx == exp_idx, "R7", "symbol index", 144'(dec_out_sym_idx), 144'(exp_idx));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(enc_out_valid == 1'b0 && dec_out_valid == 1'b0, "R10", "out_valid after reset",
              144'({enc_out_valid, dec_out_valid}), 144'(0));
        check(enc_in_ready && dec_in_ready, "R10", "in_ready after reset",
              144'({enc_in_ready, dec_in_ready}), 144'(3));
        rst_n = 1'b1;
    endtask

    task automatic t_encode_clean();
        logic [127:0] d;
        logic [143:0] w;
        for (int t = 0; t < 8; t++) begin
            d = (t == 0) ? '0 : (t == 1) ? '1 : (t == 2) ? (128'h1 << 77) : pattern(t);
            encode(d, w);
            check(w[127:0] == d, "R1", "data field", 144'(w[127:0]), 144'(d));
            check(m_synd(w) == 16'h0, "R2", "codeword syndrome", 144'(m_synd(w)), 144'(0));
            decode_expect(w, d, 3'b100, 6'd0, "R3");
        end
    endtask

    task automatic t_single();
        logic [127:0] d;
        logic [143:0] w;
        logic [3:0]   e;
        d = pattern(101);
        encode(d, w);
        for (int j = 0; j < 36; j++) begin
            e = 4'((j % 15) + 1);
            decode_expect(w ^ (144'(e) << (4 * j)), d, 3'b010, 6'(j), "R4");
        end
        for (int p = 1; p < 16; p++) begin
            decode_expect(w ^ (144'(p) << (4 * 7)), d, 3'b010, 6'd7, "R4");
            decode_expect(w ^ (144'(p) << (4 * 35)), d, 3'b010, 6'd35, "R4");
        end
    endtask

    task automatic t_double();
        logic [127:0] d;
        logic [143:0] w, bad;
        int j2;
        d = pattern(202);
        encode(d, w);
        for (int j1 = 0; j1 < 36; j1++) begin
            for (int k = 1; k < 4; k++) begin
                j2 = (j1 * 7 + 5 * k) % 36;
                if (j2 == j1) j2 = (j2 + 1) % 36;
                bad = w ^ (144'((j1 % 15) + 1) << (4 * j1))
                        ^ (144'(((j1 + 3 * k) % 15) + 1) << (4 * j2));
                decode_expect(bad, bad[127:0], 3'b001, 6'd0, "R5");
            end
        end
        bad = w ^ (144'hF << 128) ^ (144'hF << 140);
        decode_expect(bad, bad[127:0], 3'b001, 6'd0, "R5");
    endtask

    task automatic t_backpressure();
        logic [127:0] da, db;
        logic [143:0] wa, wb, wbad;
        da = pattern(303);
        db = pattern(304);
        encode(da, wa);
        encode(db, wb);
        wbad = wa ^ (144'h6 << 40);
        dec_out_ready = 1'b0;
        @(negedge clk);
        dec_in_valid = 1'b1;
        dec_in_word  = wbad;
        @(negedge clk);
        dec_in_word = wb;
        for (int c = 0; c < 3; c++) begin
            check(dec_out_valid && dec_out_data == da && dec_out_corrected && dec_out_sym_idx == 6'd10,
                  "R9", "held output", 144'(dec_out_data), 144'(da));
            check(dec_in_ready == 1'b0, "R8", "in_ready while stalled", 144'(dec_in_ready), 144'(0));
            check(enc_in_ready == 1'b1, "R11", "encode ready during decode stall",
                  144'(enc_in_ready), 144'(1));
            @(negedge clk);
        end
        dec_out_ready = 1'b1;
        @(negedge clk);
        dec_in_valid = 1'b0;
        check(dec_out_valid && dec_out_data == db && dec_out_clean, "R8", "next result after drain",
              144'(dec_out_data), 144'(db));
        @(negedge clk);
        check(dec_out_valid == 1'b0, "R8", "empty after drain", 144'(dec_out_valid), 144'(0));
    endtask

    initial begin
        t_reset();
        t_encode_clean();
        t_single();
        t_double();
        t_backpressure();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule